// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block computes cyclic redundancy checks of configurable size over a stream of data words. Software programs a generator polynomial, a register length between 1 and 32 bits and a word width between 1 and 32 bits, then writes words into a small input queue. While the engine is enabled and started, it takes one word at a time from the queue and shifts it into the CRC register a fixed number of bits per clock. Each word can enter least significant bit first or most significant bit first.

The shift structure is the augmented (non-direct) form. Message bits enter at the bottom of the CRC register, and the polynomial is folded in whenever the bit leaving the top is set. The result register therefore trails the message: it holds the true CRC only after as many zero bits as the register length have followed the last word. One all-zero word of the same width is enough for this. The start bit stays set until software writes it clear. A single sticky flag, which also drives the interrupt output, reports one of two events: the queue draining, or the last queued word being fully absorbed.

Access is through one register port with byte enables. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `crc_engine`

## Requirements
- R1: The control register (address 0) holds the register length minus one in bits 12:8 and the word width minus one in bits 20:16. Any length and width from 1 to 32 bits computes correctly, including odd widths.
- R2: The polynomial register (address 1) omits the top term. Each input bit is processed as follows: the register shifts left, the bit enters at bit 0, and the polynomial is XORed in when the bit that left position length-1 was 1. For 8 bits with polynomial 0x31, the byte 0x10 fed LSB first and flushed gives 0xB9.
- R3: The engine absorbs 2 bits per clock. An 8-bit word is taken from the queue in one cycle and absorbed over the next 4 cycles.
- R4: When the word width is 16 or less, writes to the high data register (address 3) queue nothing and leave the result unchanged.
- R5: Control bit 2 selects the bit order: 1 shifts each word LSB first, 0 shifts it MSB first. For polynomial 0x31, the byte 0x10 sent MSB first and flushed gives 0x43.
- R6: The result register (address 4) is the shift register itself, so it lags the message. With polynomial 0x31, a zero seed, LSB first and a zero flush byte, the prefixes of 10 92 C8 72 03 08 00 05 give B9, 82, 08, 9B, 94, BE, A0, 00. Without the flush, 0x10 alone reads 0x08.
- R7: The start bit (control bit 1) is never cleared by the engine.
- R8: Control bit 3 selects the flag source. With 1, the flag sets when the last queued word leaves the queue. With 0, it sets when the shift count reaches zero with the queue empty. The flag reads at control bit 4 and drives `irq`.
- R9: The flag stays set until a control write with bit 4 = 1 clears it.
- R10: A write to the result register presets the seed only while the start bit is clear. While it is set, the write is ignored.
- R11: With a word width of 8 or less, a low-data write (address 2) with only byte enable 0 queues one byte. With byte enables 1:0 it queues two words, low byte first. The queue never exceeds its depth.
- R12: After reset, control reads 0x20 (only the queue-empty bit 5 set), the result reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Sticky completion flag |

## Verification
The bench goes after the lag of the augmented structure. A design that reflected the last word at once, or that folded the polynomial on the incoming bit, would miss both the unflushed 0x08 and the prefix table that ends in zero. It times the two flag sources apart by cycle: a counter that stepped one bit per clock would raise the absorbed flag late, and a mixed-up source select would raise it at the pop. It also checks the words that are ignored: a high-data write at narrow width, or a seed write while started, would otherwise change the result. A two-byte write that queued its bytes in the wrong order would give a wrong two-byte CRC.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
    localparam int MAXW = 32;
    localparam int LENW = $clog2(MAXW);

    typedef struct packed {
        logic            enable;
        logic            go;
        logic            lsb_first;
        logic            isel;
        logic [LENW-1:0] plen_m1;
        logic [LENW-1:0] dw_m1;
    } ctrl_t;

    // ones in the low (m1+1) positions
    function automatic logic [MAXW-1:0] len_mask(input logic [LENW-1:0] m1);
        logic [MAXW:0] t;
        t = ({{MAXW{1'b0}}, 1'b1} << ({1'b0, m1} + 6'd1)) - {{MAXW{1'b0}}, 1'b1};
        return t[MAXW-1:0];
    endfunction

    // one augmented shift step
    function automatic logic [MAXW-1:0] crc_bit(input logic [MAXW-1:0] c, input logic b,
                                                input logic [MAXW-1:0] poly,
                                                input logic [LENW-1:0] plen_m1);
        logic [MAXW-1:0] n;
        n = {c[MAXW-2:0], b};
        if (c[plen_m1]) n = n ^ poly;
        return n & len_mask(plen_m1);
    endfunction

    // place the word so that the first bit to shift sits at bit 0
    function automatic logic [MAXW-1:0] order_word(input logic [MAXW-1:0] din,
                                                   input logic [LENW-1:0] dw_m1,
                                                   input logic lsb_first);
        logic [MAXW-1:0] r;
        r = '0;
        if (lsb_first) begin
            r = din & len_mask(dw_m1);
        end else begin
            for (int i = 0; i < MAXW; i++)
                if (LENW'(i) <= dw_m1) r[i] = din[dw_m1 - LENW'(i)];
        end
        return r;
    endfunction
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push1,
    input  logic                       push2,
    input  logic [W-1:0]               din0,
    input  logic [W-1:0]               din1,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic [LW-1:0] push_n;
    logic          room;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign push_n = push2 ? LW'(2) : (push1 ? LW'(1) : '0);
    assign room   = ({1'b0, f_q.lvl} + {1'b0, push_n}) <= (LW+1)'(DEPTH);

    always_comb begin
        f_d = f_q;
        if (clear) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.lvl = '0;
        end else begin
            if (pop && f_q.lvl != '0) begin
                f_d.rp  = inc(f_q.rp);
                f_d.lvl = f_d.lvl - LW'(1);
            end
            if (room && push_n != '0) begin
                f_d.mem[f_q.wp] = din0;
                if (push2) begin
                    f_d.mem[inc(f_q.wp)] = din1;
                    f_d.wp = inc(inc(f_q.wp));
                end else begin
                    f_d.wp = inc(f_q.wp);
                end
                f_d.lvl = f_d.lvl + push_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout  = f_q.mem[f_q.rp];
    assign level = f_q.lvl;
    assign empty = (f_q.lvl == '0);
endmodule

// File: rtl/crc_shifter.sv
module crc_shifter
    import crc_eng_pkg::*;
#(
    parameter int BPC = 2,
    parameter int NVW = $clog2(BPC+1)
) (
    input  logic [MAXW-1:0] crc_in,
    input  logic [BPC-1:0]  bits,
    input  logic [NVW-1:0]  take,
    input  logic [MAXW-1:0] poly,
    input  logic [LENW-1:0] plen_m1,
    output logic [MAXW-1:0] crc_out
);
    logic [BPC:0][MAXW-1:0] chain;

    assign chain[0] = crc_in;
    for (genvar g = 0; g < BPC; g++) begin : g_step
        assign chain[g+1] = (NVW'(g) < take) ? crc_bit(chain[g], bits[g], poly, plen_m1)
                                             : chain[g];
    end
    assign crc_out = chain[BPC];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
#(
    parameter int FIFO_DEPTH   = 4,
    parameter int BITS_PER_CLK = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_be,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CW  = $clog2(MAXW+1);
    localparam int NVW = $clog2(BITS_PER_CLK+1);
    localparam int LW  = $clog2(FIFO_DEPTH+1);
    localparam logic [2:0] A_CTRL = 3'd0, A_POLY = 3'd1, A_DLO = 3'd2,
                           A_DHI = 3'd3, A_RES = 3'd4;

    typedef struct packed {
        ctrl_t           ctrl;
        logic            flag;
        logic [MAXW-1:0] poly;
        logic [MAXW-1:0] crc;
        logic [15:0]     lo_hold;
        logic [MAXW-1:0] word;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;

    logic            f_push1, f_push2, f_pop, f_clear, f_empty;
    logic [MAXW-1:0] f_din0, f_din1, f_dout;
    logic [LW-1:0]   f_level;
    logic [CW-1:0]   take_c;
    logic [MAXW-1:0] sh_out;
    logic            ev_set;

    crc_fifo #(.W(MAXW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(f_clear), .push1(f_push1), .push2(f_push2),
        .din0(f_din0), .din1(f_din1), .pop(f_pop), .dout(f_dout),
        .level(f_level), .empty(f_empty)
    );

    assign take_c = (st_q.cnt > CW'(BITS_PER_CLK)) ? CW'(BITS_PER_CLK) : st_q.cnt;

    crc_shifter #(.BPC(BITS_PER_CLK), .NVW(NVW)) u_shift (
        .crc_in(st_q.crc), .bits(st_q.word[BITS_PER_CLK-1:0]), .take(NVW'(take_c)),
        .poly(st_q.poly), .plen_m1(st_q.ctrl.plen_m1), .crc_out(sh_out)
    );

    always_comb begin
        st_d    = st_q;
        f_push1 = 1'b0;
        f_push2 = 1'b0;
        f_din0  = '0;
        f_din1  = '0;
        f_pop   = 1'b0;
        f_clear = 1'b0;
        ev_set  = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    if (reg_be[0]) begin
                        st_d.ctrl.enable    = reg_wdata[0];
                        st_d.ctrl.go        = reg_wdata[1];
                        st_d.ctrl.lsb_first = reg_wdata[2];
                        st_d.ctrl.isel      = reg_wdata[3];
                        if (reg_wdata[4]) st_d.flag = 1'b0;
                    end
                    if (reg_be[1]) st_d.ctrl.plen_m1 = reg_wdata[12:8];
                    if (reg_be[2]) st_d.ctrl.dw_m1   = reg_wdata[20:16];
                end
                A_POLY: begin
                    for (int b = 0; b < 4; b++)
                        if (reg_be[b]) st_d.poly[8*b +: 8] = reg_wdata[8*b +: 8];
                end
                A_RES: begin
                    if (!st_q.ctrl.go)
                        for (int b = 0; b < 4; b++)
                            if (reg_be[b]) st_d.crc[8*b +: 8] = reg_wdata[8*b +: 8];
                end
                A_DLO: begin
                    if (st_q.ctrl.enable) begin
                        if (st_q.ctrl.dw_m1 < LENW'(8)) begin
                            if (reg_be[1:0] == 2'b11) begin
                                f_push2 = 1'b1;
                                f_din0  = {24'b0, reg_wdata[7:0]};
                                f_din1  = {24'b0, reg_wdata[15:8]};
                            end else if (reg_be[0]) begin
                                f_push1 = 1'b1;
                                f_din0  = {24'b0, reg_wdata[7:0]};
                            end else if (reg_be[1]) begin
                                f_push1 = 1'b1;
                                f_din0  = {24'b0, reg_wdata[15:8]};
                            end
                        end else if (st_q.ctrl.dw_m1 < LENW'(16)) begin
                            if (|reg_be[1:0]) begin
                                f_push1 = 1'b1;
                                f_din0  = {16'b0, reg_wdata[15:0]};
                            end
                        end else begin
                            if (reg_be[0]) st_d.lo_hold[7:0]  = reg_wdata[7:0];
                            if (reg_be[1]) st_d.lo_hold[15:8] = reg_wdata[15:8];
                        end
                    end
                end
                A_DHI: begin
                    if (st_q.ctrl.enable && st_q.ctrl.dw_m1 >= LENW'(16) && |reg_be[1:0]) begin
                        f_push1 = 1'b1;
                        f_din0  = {reg_wdata[15:0], st_q.lo_hold};
                    end
                end
                default: ;
            endcase
        end

        if (!st_q.ctrl.enable) begin
            f_clear  = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.ctrl.go) begin
            if (st_q.cnt == '0) begin
                if (!f_empty) begin
                    f_pop     = 1'b1;
                    st_d.word = order_word(f_dout, st_q.ctrl.dw_m1, st_q.ctrl.lsb_first);
                    st_d.cnt  = CW'(st_q.ctrl.dw_m1) + CW'(1);
                    if (st_q.ctrl.isel && f_level == LW'(1)) ev_set = 1'b1;
                end
            end else begin
                st_d.crc  = sh_out;
                st_d.word = st_q.word >> take_c;
                st_d.cnt  = st_q.cnt - take_c;
                if (!st_q.ctrl.isel && st_q.cnt <= CW'(BITS_PER_CLK) && f_empty) ev_set = 1'b1;
            end
        end

        if (ev_set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {11'b0, st_q.ctrl.dw_m1, 3'b0, st_q.ctrl.plen_m1, 2'b0,
                                  f_empty, st_q.flag, st_q.ctrl.isel, st_q.ctrl.lsb_first,
                                  st_q.ctrl.go, st_q.ctrl.enable};
            A_POLY:  reg_rdata = st_q.poly;
            A_RES:   reg_rdata = st_q.crc;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = st_q.flag;

    // plain views for the bound checker
    logic            go_q, flag_q, active_q;
    logic [CW-1:0]   cnt_q;
    logic [MAXW-1:0] crc_q;
    logic [LENW-1:0] dw_m1_q;
    assign go_q     = st_q.ctrl.go;
    assign flag_q   = st_q.flag;
    assign active_q = st_q.ctrl.enable & st_q.ctrl.go;
    assign cnt_q    = st_q.cnt;
    assign crc_q    = st_q.crc;
    assign dw_m1_q  = st_q.ctrl.dw_m1;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
    parameter int BPC   = 2,
    parameter int DEPTH = 4,
    parameter int LW    = 3,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [3:0]    reg_be,
    input logic [31:0]   reg_wdata,
    input logic          go,
    input logic          flag,
    input logic          active,
    input logic [CW-1:0] cnt,
    input logic [31:0]   crc,
    input logic [LW-1:0] fifo_level,
    input logic [4:0]    dw_m1
);
    logic ctrl_wr, flag_clr;
    assign ctrl_wr  = reg_wr && reg_addr == 3'd0 && reg_be[0];
    assign flag_clr = ctrl_wr && reg_wdata[4];

    // R7
    go_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ctrl_wr) |=> go);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R10
    seed_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt == '0) |=> $stable(crc));

    // R3
    two_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt > CW'(BPC)) |=> cnt == $past(cnt) - CW'(BPC));

    // R4
    hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && dw_m1 < 5'd16) |=> fifo_level <= $past(fifo_level));

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));
endmodule

bind crc_engine crc_engine_chk #(
    .BPC(BITS_PER_CLK), .DEPTH(FIFO_DEPTH), .LW(LW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .go(go_q), .flag(flag_q), .active(active_q), .cnt(cnt_q),
    .crc(crc_q), .fifo_level(f_level), .dw_m1(dw_m1_q)
);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    crc_engine dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .irq(irq));

    always #5 clk = ~clk;

    localparam logic [7:0] MSG [8] = '{8'h10, 8'h92, 8'hC8, 8'h72, 8'h03, 8'h08, 8'h00, 8'h05};
    localparam logic [7:0] EXP [8] = '{8'hB9, 8'h82, 8'h08, 8'h9B, 8'h94, 8'hBE, 8'hA0, 8'h00};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit en, input bit go, input bit lsb,
                                            input bit isel, input bit clr,
                                            input int plen, input int dw);
        return {11'b0, 5'(dw-1), 3'b0, 5'(plen-1), 3'b0, clr, isel, lsb, go, en};
    endfunction

    // bitwise reference of the augmented shift
    function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] w,
                                          input int dw, input int plen,
                                          input logic [31:0] poly, input bit lsb);
        logic [31:0] m;
        m = (plen == 32) ? 32'hFFFF_FFFF : ((32'd1 << plen) - 32'd1);
        for (int i = 0; i < dw; i++) begin
            logic b, fb;
            b  = lsb ? w[i] : w[dw-1-i];
            fb = c[plen-1];
            c  = (c << 1) | {31'b0, b};
            if (fb) c = c ^ poly;
            c = c & m;
        end
        return c;
    endfunction

    task automatic restart(input bit lsb, input int plen, input int dw);
        wr(3'd0, mk_ctrl(1, 0, lsb, 0, 1, plen, dw), 4'b0111);
        wr(3'd4, 32'h0, 4'hF);
        wr(3'd0, mk_ctrl(1, 1, lsb, 0, 1, plen, dw), 4'b0111);
    endtask

    task automatic push_byte(input logic [7:0] b);
        wr(3'd2, {24'b0, b}, 4'b0001);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, keep, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        rd(3'd0, v); check("R12 ctrl", v, 32'h20);
        rd(3'd4, v); check("R12 result", v, 32'h0);
        check("R12 irq", {31'b0, irq}, 32'h0);

        wr(3'd1, 32'h31, 4'hF);

        // R6 prefix table, zero flush word each time
        for (int n = 1; n <= 8; n++) begin
            restart(1, 8, 8);
            for (int k = 0; k < n; k++) push_byte(MSG[k]);
            push_byte(8'h00);
            rd(3'd4, v);
            check($sformatf("R6 prefix %0d", n), v, {24'b0, EXP[n-1]});
        end

        // R7 start bit remains set after completion
        rd(3'd0, v); check("R7 go", {31'b0, v[1]}, 32'h1);

        // R6 lag before flush, R2 value after flush
        restart(1, 8, 8);
        push_byte(8'h10);
        rd(3'd4, v); check("R6 unflushed", v, 32'h08);
        push_byte(8'h00);
        rd(3'd4, v); check("R2 poly without top term", v, 32'hB9);

        // R5 MSB first
        restart(0, 8, 8);
        push_byte(8'h10); push_byte(8'h00);
        rd(3'd4, v); check("R5 msb first", v, 32'h43);
        restart(0, 8, 8);
        push_byte(8'hA7); push_byte(8'h00);
        e = model(model(0, 32'hA7, 8, 8, 32'h31, 0), 0, 8, 8, 32'h31, 0);
        rd(3'd4, v); check("R5 msb first model", v, e);

        // R11 two bytes in one write, low first
        restart(1, 8, 8);
        wr(3'd2, 32'h9210, 4'b0011);
        repeat (12) @(negedge clk);
        push_byte(8'h00);
        rd(3'd4, v); check("R11 two-byte write", v, 32'h82);

        // R4 high data ignored at narrow width
        rd(3'd4, keep);
        wr(3'd3, 32'hFFFF, 4'b0011);
        repeat (8) @(negedge clk);
        rd(3'd0, v); check("R4 queue empty", {31'b0, v[5]}, 32'h1);
        rd(3'd4, v); check("R4 result kept", v, keep);

        // R10 seed guard
        wr(3'd4, 32'h55, 4'hF);
        rd(3'd4, v); check("R10 write ignored while go", v, keep);
        wr(3'd0, mk_ctrl(1, 0, 1, 0, 0, 8, 8), 4'b0111);
        wr(3'd4, 32'h55, 4'hF);
        rd(3'd4, v); check("R10 seed written", v, 32'h55);

        // R8 queue-empty source: flag at the pop
        wr(3'd0, mk_ctrl(1, 1, 1, 1, 1, 8, 8), 4'b0111);
        wr(3'd2, 32'h10, 4'b0001);
        @(negedge clk);
        check("R8 empty source", {31'b0, irq}, 32'h1);
        repeat (8) @(negedge clk);

        // R8 and R3 absorbed source: 4 cycles after the pop
        wr(3'd0, mk_ctrl(1, 1, 1, 0, 1, 8, 8), 4'b0111);
        wr(3'd2, 32'h10, 4'b0001);
        @(negedge clk);
        check("R8 absorbed source not at pop", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        check("R3 not yet absorbed", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R3 absorbed after four cycles", {31'b0, irq}, 32'h1);

        // R9 flag persists until written
        repeat (10) @(negedge clk);
        rd(3'd0, v); check("R9 flag held", {31'b0, v[4]}, 32'h1);
        wr(3'd0, mk_ctrl(1, 1, 1, 0, 1, 8, 8), 4'b0111);
        check("R9 flag cleared", {31'b0, irq}, 32'h0);

        // R1 wide and odd sizes
        wr(3'd1, 32'h1021, 4'hF);
        restart(0, 16, 16);
        wr(3'd2, 32'h1234, 4'b0011); repeat (12) @(negedge clk);
        wr(3'd2, 32'h0, 4'b0011);    repeat (12) @(negedge clk);
        e = model(model(0, 32'h1234, 16, 16, 32'h1021, 0), 0, 16, 16, 32'h1021, 0);
        rd(3'd4, v); check("R1 16-bit", v, e);

        wr(3'd1, 32'h04C1_1DB7, 4'hF);
        restart(1, 32, 32);
        wr(3'd2, 32'h5678, 4'b0011); wr(3'd3, 32'h1234, 4'b0011); repeat (20) @(negedge clk);
        wr(3'd2, 32'h0, 4'b0011);    wr(3'd3, 32'h0, 4'b0011);    repeat (20) @(negedge clk);
        e = model(model(0, 32'h1234_5678, 32, 32, 32'h04C1_1DB7, 1), 0, 32, 32, 32'h04C1_1DB7, 1);
        rd(3'd4, v); check("R1 32-bit", v, e);

        wr(3'd1, 32'h05, 4'hF);
        restart(1, 5, 5);
        push_byte(8'h13); push_byte(8'h00);
        e = model(model(0, 32'h13, 5, 5, 32'h05, 1), 0, 5, 5, 32'h05, 1);
        rd(3'd4, v); check("R1 5-bit odd width", v, e);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule